// File: doc/BRIEF.md
# Reset Strap and Shared-Pin Controller

This block owns a small group of chip pins whose meaning depends on reset. While the reset input is low, the pins are configuration straps. Three dedicated pins and one shared pin form a 4-bit boot-mode word. A second shared pin gives the PLL-enable setting. On the first clock edge after reset release has been synchronised, these levels are latched into a mode register and a PLL-enable bit. Both then hold their values until the next reset. A software write can also change them, if the build enables that write path.

After capture, the shared pins take on their run-time roles. The first becomes a PLL lock indicator. It can instead be set as a general-purpose pin, in one of three modes: input, output, or disconnected. The second becomes a non-maskable interrupt request. It passes through a two-flop synchroniser, and each falling edge produces a single-cycle pulse. The edge detector is armed only after capture. A pin that is still low when reset ends therefore raises no interrupt.

Top module: `strap_pin_ctrl`

## Requirements
- R1: While `rst_pin_n` is low, `dual_pin_oe`, `dual_pin_o`, `gpio_din_o`, `nmi_pulse_o`, `op_mode_o` and `pll_en_o` are all 0.
- R2: `op_mode_o` is captured on the third rising clock edge after `rst_pin_n` rises. Before that edge it reads 0. The bit layout is: bit 0 from `mode_straps_i[0]`, bit 1 from `mode_straps_i[1]`, bit 2 from the synchronised `dual_pin_i` level, and bit 3 from `mode_straps_i[2]`.
- R3: On that same edge, `pll_en_o` takes the synchronised level of `pinit_nmi_i`.
- R4: After capture, `op_mode_o` and `pll_en_o` ignore every strap pin. They change only on a write or on a new reset.
- R5: With `gpio_cfg_i` = 2'b00 (lock function) after capture, `dual_pin_oe` is 1 and `dual_pin_o` equals `pll_locked_i`.
- R6: After capture, each 1-to-0 transition of `pinit_nmi_i` gives exactly one high cycle of `nmi_pulse_o`. That cycle follows the second rising edge after the fall. A rising edge gives no pulse, and a level held low gives no further pulse.
- R7: With `gpio_cfg_i` = 2'b10 (GPIO output), `dual_pin_oe` is 1 and `dual_pin_o` equals `gpio_dout_i`.
- R8: With `gpio_cfg_i` = 2'b01 (GPIO input), `dual_pin_oe` is 0 and `gpio_din_o` follows `dual_pin_i` two clock edges later. In every other mode, `gpio_din_o` is 0.
- R9: With `gpio_cfg_i` = 2'b11 (disconnected), `dual_pin_oe`, `dual_pin_o` and `gpio_din_o` are all 0, whatever the pin does.
- R10: When `WRITE_PATH_EN` is 1 and capture is complete, a cycle with `wr_en_i` high loads `wr_mode_i` and `wr_pll_en_i` on that edge. A write on the capture edge or earlier is ignored.
- R11: If `pinit_nmi_i` is low at reset exit, no pulse is produced until the pin has gone high and then falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Chip reset, active low; takes effect at once, released through a synchroniser |
| mode_straps_i | input | MODE_W-1 | Dedicated boot-mode strap pins |
| dual_pin_i | input | 1 | Pad input of the lock/GPIO shared pin (mode strap while in reset) |
| dual_pin_o | output | 1 | Pad output of the shared pin |
| dual_pin_oe | output | 1 | Pad output enable of the shared pin |
| pinit_nmi_i | input | 1 | PLL-enable strap in reset, NMI request afterwards |
| pll_locked_i | input | 1 | PLL lock flag |
| gpio_cfg_i | input | 2 | Shared pin function: 00 lock, 01 input, 10 output, 11 disconnected |
| gpio_dout_i | input | 1 | GPIO output data |
| gpio_din_o | output | 1 | GPIO input data (synchronised) |
| wr_en_i | input | 1 | Write strobe for the latched settings |
| wr_mode_i | input | MODE_W | Mode value to write |
| wr_pll_en_i | input | 1 | PLL-enable value to write |
| op_mode_o | output | MODE_W | Latched operating mode |
| pll_en_o | output | 1 | Latched PLL enable |
| nmi_pulse_o | output | 1 | Single-cycle NMI request |

## Verification
The checker checks on every cycle that the pad stays undriven and the interrupt stays quiet until capture. It also checks that the latched settings hold when no write is present, that the lock function mirrors the lock flag, that the disconnected mode stays silent, and that an NMI pulse lasts one cycle. Some behaviours can only be shown by the bench's scenarios. These are the exact capture edge and the bit placement of the mode word, the two-edge latency of GPIO input and NMI, a write on the capture edge losing to capture, and the absence of a pulse when the NMI pin is low at reset exit.

// File: rtl/strap_pin_pkg.sv
package strap_pin_pkg;

   // Function of the shared lock/GPIO pin once strap capture is complete
   typedef enum logic [1:0] {
      PIN_FN_LOCK     = 2'b00,
      PIN_FN_GPIO_IN  = 2'b01,
      PIN_FN_GPIO_OUT = 2'b10,
      PIN_FN_GPIO_OFF = 2'b11
   } pin_fn_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/spc_reset_sync.sv
module spc_reset_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_sync_n
);

   logic [STAGES-1:0] chain_q;

   // immediate assertion, release shifted through STAGES flops
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/spc_bit_sync.sv
module spc_bit_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);

   // left free-running so the chain already carries the pin level during reset
   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk) begin
      ff_q <= {ff_q[STAGES-2:0], d};
   end

   assign q = ff_q[STAGES-1];

endmodule

// File: rtl/spc_strap_latch.sv
module spc_strap_latch #(
   parameter int unsigned MODE_W        = 4,
   parameter int unsigned SHARED_IDX    = 2,
   parameter bit          WRITE_PATH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-2:0] ded_straps,
   input  logic              shared_lvl,
   input  logic              pinit_lvl,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic              wr_pll_en,
   output logic [MODE_W-1:0] op_mode,
   output logic              pll_en,
   output logic              armed
);

   logic [MODE_W-1:0] merged;
   logic              wr_hit;

   // splice the shared pin level into the dedicated strap word
   for (genvar i = 0; i < MODE_W; i++) begin : g_merge
      if (i < SHARED_IDX) begin : g_lo
         assign merged[i] = ded_straps[i];
      end else if (i == SHARED_IDX) begin : g_sh
         assign merged[i] = shared_lvl;
      end else begin : g_hi
         assign merged[i] = ded_straps[i-1];
      end
   end

   if (WRITE_PATH_EN) begin : g_wr
      assign wr_hit = wr_en;
   end else begin : g_no_wr
      assign wr_hit = 1'b0;
   end

   // first edge with armed low after release is the capture edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_mode <= '0;
         pll_en  <= 1'b0;
         armed   <= 1'b0;
      end else if (!armed) begin
         op_mode <= merged;
         pll_en  <= pinit_lvl;
         armed   <= 1'b1;
      end else if (wr_hit) begin
         op_mode <= wr_mode;
         pll_en  <= wr_pll_en;
      end
   end

endmodule

// File: rtl/spc_nmi_edge.sv
module spc_nmi_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic lvl,
   output logic pulse
);

   logic prev_q;
   logic valid_q;

   // history is only trusted once a sample has been taken while enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b1;
         valid_q <= 1'b0;
      end else if (enable) begin
         prev_q  <= lvl;
         valid_q <= 1'b1;
      end else begin
         valid_q <= 1'b0;
      end
   end

   assign pulse = enable & valid_q & prev_q & ~lvl;

endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl
   import strap_pin_pkg::*;
#(
   parameter int unsigned MODE_W        = 4,
   parameter int unsigned SHARED_IDX    = 2,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          WRITE_PATH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_pin_n,
   input  logic [MODE_W-2:0] mode_straps_i,
   input  logic              dual_pin_i,
   output logic              dual_pin_o,
   output logic              dual_pin_oe,
   input  logic              pinit_nmi_i,
   input  logic              pll_locked_i,
   input  logic [1:0]        gpio_cfg_i,
   input  logic              gpio_dout_i,
   output logic              gpio_din_o,
   input  logic              wr_en_i,
   input  logic [MODE_W-1:0] wr_mode_i,
   input  logic              wr_pll_en_i,
   output logic [MODE_W-1:0] op_mode_o,
   output logic              pll_en_o,
   output logic              nmi_pulse_o
);

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("strap_pin_ctrl: SYNC_STAGES below minimum");
   end
   if (MODE_W < 2) begin : g_bad_width
      $error("strap_pin_ctrl: MODE_W must be at least 2");
   end
   if (SHARED_IDX >= MODE_W) begin : g_bad_idx
      $error("strap_pin_ctrl: SHARED_IDX outside mode word");
   end

   logic    rst_sync_n;
   logic    dual_sync;
   logic    nmi_sync;
   logic    armed;
   pin_fn_e pin_fn;

   spc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
      .clk        (clk),
      .arst_n     (rst_pin_n),
      .rst_sync_n (rst_sync_n)
   );

   spc_bit_sync #(.STAGES(SYNC_STAGES)) u_dual_sync (
      .clk (clk),
      .d   (dual_pin_i),
      .q   (dual_sync)
   );

   spc_bit_sync #(.STAGES(SYNC_STAGES)) u_nmi_sync (
      .clk (clk),
      .d   (pinit_nmi_i),
      .q   (nmi_sync)
   );

   spc_strap_latch #(
      .MODE_W        (MODE_W),
      .SHARED_IDX    (SHARED_IDX),
      .WRITE_PATH_EN (WRITE_PATH_EN)
   ) u_latch (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ded_straps (mode_straps_i),
      .shared_lvl (dual_sync),
      .pinit_lvl  (nmi_sync),
      .wr_en      (wr_en_i),
      .wr_mode    (wr_mode_i),
      .wr_pll_en  (wr_pll_en_i),
      .op_mode    (op_mode_o),
      .pll_en     (pll_en_o),
      .armed      (armed)
   );

   spc_nmi_edge u_nmi (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .enable (armed),
      .lvl    (nmi_sync),
      .pulse  (nmi_pulse_o)
   );

   assign pin_fn = pin_fn_e'(gpio_cfg_i);

   // shared pad: input-only strap until armed, then the selected function
   always_comb begin
      dual_pin_oe = 1'b0;
      dual_pin_o  = 1'b0;
      gpio_din_o  = 1'b0;
      if (armed) begin
         case (pin_fn)
            PIN_FN_LOCK: begin
               dual_pin_oe = 1'b1;
               dual_pin_o  = pll_locked_i;
            end
            PIN_FN_GPIO_OUT: begin
               dual_pin_oe = 1'b1;
               dual_pin_o  = gpio_dout_i;
            end
            PIN_FN_GPIO_IN: begin
               gpio_din_o  = dual_sync;
            end
            default: begin
            end
         endcase
      end
   end

endmodule

// File: rtl/strap_pin_ctrl_chk.sv
module strap_pin_ctrl_chk #(
   parameter int unsigned MODE_W = 4
) (
   input logic              clk,
   input logic              rst_pin_n,
   input logic              armed,
   input logic [1:0]        gpio_cfg_i,
   input logic              pll_locked_i,
   input logic              dual_pin_o,
   input logic              dual_pin_oe,
   input logic              gpio_din_o,
   input logic              wr_en_i,
   input logic [MODE_W-1:0] op_mode_o,
   input logic              pll_en_o,
   input logic              nmi_pulse_o
);

   // R1
   quiet_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
      !armed |-> (!dual_pin_oe && !dual_pin_o && !gpio_din_o && !nmi_pulse_o));

   // R2
   armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
      armed |=> armed);

   // R4
   settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (armed && !wr_en_i) |=> ($stable(op_mode_o) && $stable(pll_en_o)));

   // R5
   lock_mirror_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (armed && gpio_cfg_i == 2'b00) |-> (dual_pin_oe && dual_pin_o == pll_locked_i));

   // R6
   nmi_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
      nmi_pulse_o |=> !nmi_pulse_o);

   // R11
   nmi_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
      nmi_pulse_o |-> $past(armed));

   // R9
   off_silent_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (gpio_cfg_i == 2'b11) |-> (!dual_pin_oe && !dual_pin_o && !gpio_din_o));

endmodule

bind strap_pin_ctrl strap_pin_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
   .clk          (clk),
   .rst_pin_n    (rst_pin_n),
   .armed        (armed),
   .gpio_cfg_i   (gpio_cfg_i),
   .pll_locked_i (pll_locked_i),
   .dual_pin_o   (dual_pin_o),
   .dual_pin_oe  (dual_pin_oe),
   .gpio_din_o   (gpio_din_o),
   .wr_en_i      (wr_en_i),
   .op_mode_o    (op_mode_o),
   .pll_en_o     (pll_en_o),
   .nmi_pulse_o  (nmi_pulse_o)
);

// File: tb/strap_pin_ctrl_bench.sv
`timescale 1ns/1ps
module strap_pin_ctrl_bench;

   localparam int MW = 4;

   logic          clk = 1'b0;
   logic          rst_pin_n = 1'b0;
   logic [MW-2:0] mode_straps_i = '0;
   logic          dual_pin_i = 1'b0;
   logic          dual_pin_o, dual_pin_oe;
   logic          pinit_nmi_i = 1'b1;
   logic          pll_locked_i = 1'b0;
   logic [1:0]    gpio_cfg_i = 2'b00;
   logic          gpio_dout_i = 1'b0;
   logic          gpio_din_o;
   logic          wr_en_i = 1'b0;
   logic [MW-1:0] wr_mode_i = '0;
   logic          wr_pll_en_i = 1'b0;
   logic [MW-1:0] op_mode_o;
   logic          pll_en_o;
   logic          nmi_pulse_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int pulse_cnt = 0;
   bit done = 1'b0;
   int exp_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   strap_pin_ctrl u_strap_pin_ctrl (
      .clk           (clk),
      .rst_pin_n     (rst_pin_n),
      .mode_straps_i (mode_straps_i),
      .dual_pin_i    (dual_pin_i),
      .dual_pin_o    (dual_pin_o),
      .dual_pin_oe   (dual_pin_oe),
      .pinit_nmi_i   (pinit_nmi_i),
      .pll_locked_i  (pll_locked_i),
      .gpio_cfg_i    (gpio_cfg_i),
      .gpio_dout_i   (gpio_dout_i),
      .gpio_din_o    (gpio_din_o),
      .wr_en_i       (wr_en_i),
      .wr_mode_i     (wr_mode_i),
      .wr_pll_en_i   (wr_pll_en_i),
      .op_mode_o     (op_mode_o),
      .pll_en_o      (pll_en_o),
      .nmi_pulse_o   (nmi_pulse_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: each NMI pulse must match the head of the queue
   always @(negedge clk) begin
      if (rst_pin_n) begin
         if (exp_q.size() != 0 && exp_q[0] < cyc) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 missing pulse actual=0 expected=1 (cycle %0d)", exp_q[0]);
            void'(exp_q.pop_front());
         end
         if (nmi_pulse_o) begin
            pulse_cnt++;
            n_chk++;
            if (exp_q.size() != 0 && exp_q[0] == cyc) begin
               void'(exp_q.pop_front());
            end else begin
               n_fail++;
               $display("FAIL R6 R11 unexpected pulse actual=1 expected=0 (cycle %0d)", cyc);
            end
         end
      end
   end

   // driver: falling edge on the NMI pin, pulse expected two edges later
   task automatic nmi_fall();
      @(negedge clk);
      pinit_nmi_i = 1'b0;
      exp_q.push_back(cyc + 2);
      repeat (6) @(negedge clk);
      pinit_nmi_i = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_reset(input logic [MW-1:0] m, input logic p, input logic wr_during);
      int c0;
      @(negedge clk);
      rst_pin_n     = 1'b0;
      mode_straps_i = {m[3], m[1], m[0]};
      dual_pin_i    = m[2];
      pinit_nmi_i   = p;
      wr_en_i       = wr_during;
      wr_mode_i     = 4'hF;
      wr_pll_en_i   = ~p;
      gpio_cfg_i    = 2'b00;
      pll_locked_i  = 1'b0;
      repeat (4) @(negedge clk);
      // R1 reset state of every output
      chk("R1 outputs in reset",
          {26'd0, dual_pin_oe, dual_pin_o, gpio_din_o, nmi_pulse_o, pll_en_o, |op_mode_o}, 32'd0);
      rst_pin_n = 1'b1;
      c0 = cyc;
      @(negedge clk);
      @(negedge clk);
      // R2 not yet captured two edges after release
      chk("R2 before capture edge", {28'd0, op_mode_o}, 32'd0);
      @(negedge clk);
      chk("R2 mode captured", {28'd0, op_mode_o}, {28'd0, m});
      chk("R3 pll enable captured", {31'd0, pll_en_o}, {31'd0, p});
      chk("R2 capture edge count", cyc - c0, 32'd3);
      wr_en_i = 1'b0;
   endtask

   initial begin
      repeat (2) @(negedge clk);

      // first reset: mode 1010, PLL enabled
      do_reset(4'b1010, 1'b1, 1'b0);

      // R4 strap pins change after capture
      mode_straps_i = 3'b101;
      dual_pin_i    = 1'b1;
      repeat (4) @(negedge clk);
      chk("R4 mode holds after strap change", {28'd0, op_mode_o}, 32'ha);
      chk("R4 pll enable holds", {31'd0, pll_en_o}, 32'd1);

      // R5 lock indicator
      chk("R5 lock drive unlocked", {30'd0, dual_pin_oe, dual_pin_o}, 32'b10);
      pll_locked_i = 1'b1;
      @(negedge clk);
      chk("R5 lock drive locked", {30'd0, dual_pin_oe, dual_pin_o}, 32'b11);

      // R6 NMI pulses through scoreboard
      nmi_fall();
      nmi_fall();
      chk("R6 pulse count after two falls", pulse_cnt, 32'd2);

      // R7 GPIO output
      gpio_cfg_i  = 2'b10;
      gpio_dout_i = 1'b1;
      @(negedge clk);
      chk("R7 gpio out high", {30'd0, dual_pin_oe, dual_pin_o}, 32'b11);
      gpio_dout_i = 1'b0;
      @(negedge clk);
      chk("R7 gpio out low", {30'd0, dual_pin_oe, dual_pin_o}, 32'b10);
      chk("R8 din zero in output mode", {31'd0, gpio_din_o}, 32'd0);

      // R8 GPIO input with two-edge latency
      dual_pin_i = 1'b0;
      gpio_cfg_i = 2'b01;
      repeat (3) @(negedge clk);
      chk("R8 gpio in releases pad", {31'd0, dual_pin_oe}, 32'd0);
      dual_pin_i = 1'b1;
      @(negedge clk);
      chk("R8 gpio in after one edge", {31'd0, gpio_din_o}, 32'd0);
      @(negedge clk);
      chk("R8 gpio in after two edges", {31'd0, gpio_din_o}, 32'd1);

      // R9 disconnected
      gpio_cfg_i  = 2'b11;
      gpio_dout_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 disconnected silent", {29'd0, dual_pin_oe, dual_pin_o, gpio_din_o}, 32'd0);

      // R10 write path after capture
      @(negedge clk);
      wr_en_i     = 1'b1;
      wr_mode_i   = 4'h6;
      wr_pll_en_i = 1'b0;
      @(negedge clk);
      wr_en_i = 1'b0;
      chk("R10 written mode", {28'd0, op_mode_o}, 32'h6);
      chk("R10 written pll enable", {31'd0, pll_en_o}, 32'd0);

      // second reset: NMI pin low at exit, write held over the capture edge
      do_reset(4'b0101, 1'b0, 1'b1);
      @(negedge clk);
      chk("R10 write on capture edge ignored", {28'd0, op_mode_o}, 32'h5);
      repeat (10) @(negedge clk);
      chk("R11 no pulse with pin low at exit", pulse_cnt, 32'd2);
      pinit_nmi_i = 1'b1;
      repeat (4) @(negedge clk);
      chk("R11 no pulse on rising pin", pulse_cnt, 32'd2);
      nmi_fall();
      chk("R6 pulse after rearm", pulse_cnt, 32'd3);
      repeat (3) @(negedge clk);
      chk("R6 scoreboard drained", exp_q.size(), 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule